// File: doc/BRIEF.md
# Configuration Address Translating Bridge

This block sits between a host register bus and a downstream configuration port. The host sees two 4 KiB windows. Address bit 12 selects the window: 0 is the index window and 1 is the data window. Any write to the index window stores a 32-bit configuration index, and any read of that window returns the stored index. Each access to the data window turns the stored index and the low bits of the window offset into one downstream address. The bridge then issues a single read or write request on the downstream port. A read returns the downstream reply to the host. The data word passes through unchanged, with byte 0 in bits [7:0].

Software selects a device on the local bus in slot-select form, where one bit in index bits [31:11] is set per device. The bridge turns that form into the conventional enable/device/function/register layout. Two other index forms pass through with only their low bits merged. An index that selects no device is answered locally and never reaches the downstream port. A separate combinational router folds four interrupt pins per attached device onto four interrupt lines, rotating them by device number. Lines 0 to 3 feed interrupt controller inputs 27 to 30 in that order.

All three data paths use valid/ready handshakes: host request, host response and downstream request. A request is held, with all of its fields stable, until its ready is seen high at a clock edge. Only one host access is in flight at a time: `host_ready` stays low from acceptance until the response handshake. Downstream read data comes back on `dn_rsp_valid`, which the bridge always accepts while it waits.

Top module: `cfg_xlate_bridge`

## Requirements
- R1: A write to the index window (host_addr[12]=0, any offset) stores host_wdata at the accepting clock edge. A later index-window read returns that value, and any data access after it uses it.
- R2: Pass-through form. If index bit 31 is set, the downstream address is the index with bits [1:0] ORed with host_addr[1:0]. Offset bits [11:2] are ignored.
- R3: Other-bus form. If index bit 31 is clear and bit 0 is set, the downstream address is index bits [31:3] followed by host_addr[2:0].
- R4: Slot-select form. If index bits 31 and 0 are both clear, the device number is the position (11 to 30) of the lowest set bit in index bits [31:11]. The output carries it in bits [15:11], with bit 31 set and bits [30:16] clear.
- R5: In slot-select form, output bits [10:8] are index bits [10:8] and output bits [7:3] are index bits [7:3]. Output bits [2:0] are host_addr[2:0]. Index bits [2:1] and offset bits [11:3] have no effect.
- R6: In slot-select form with index bits [31:11] all zero, a data read returns 0xFFFFFFFF and a data write is dropped. In both cases no downstream request is raised.
- R7: dn_valid holds dn_addr, dn_write and dn_wdata stable until dn_ready. A write completes at its handshake. A read waits for dn_rsp_valid and returns dn_rsp_data to the host.
- R8: rsp_valid holds rsp_data stable until rsp_ready. host_ready is low from request acceptance until the response handshake, and the response to a write carries zero.
- R9: irq_line[n] is the OR of every pin p (dev_irq[4k+p]) of attached device k with (p + DEV_BASE + k) mod 4 = n.
- R10: After reset the index is zero, host_ready is high, and dn_valid and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request accepted when high at an edge with host_valid |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | WIN_W+1 | Bit WIN_W selects the data window; the lower bits are the window offset |
| host_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Host response valid |
| rsp_ready | input | 1 | Host response taken |
| rsp_data | output | 32 | Read data; zero for writes |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request taken |
| dn_write | output | 1 | Downstream request is a write |
| dn_addr | output | 32 | Translated configuration address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream read data valid |
| dn_rsp_data | input | 32 | Downstream read data |
| dev_irq | input | 4*NDEV | Pin p of attached device k at bit 4k+p |
| irq_line | output | 4 | Rotated interrupt lines |

## Verification
The checker assumes the environment follows the handshakes. dn_rsp_valid arrives only while a read is outstanding, and host requests only matter while host_ready is high. The bench raises a request, drops it as soon as it is accepted, and answers a downstream request only after seeing dn_valid. Stalls of zero to three cycles on dn_ready and rsp_ready exercise the hold rules. The bench sweeps every slot bit, every function number and every offset pattern against an arithmetic model. It also drives the interrupt inputs through all 256 patterns of a two-device setup.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int CFG_W = 32;
  localparam int SLOT_LO = 11;
  localparam int DEV_W = 5;
  localparam int IRQ_LINES = 4;
  localparam int IRQ_CTRL_BASE = 27;
  localparam logic [CFG_W-1:0] CFG_NO_DEV = '1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } cfgb_state_e;
endpackage

// File: rtl/cfgb_xlate.sv
module cfgb_xlate
  import cfgb_pkg::*;
#(
  parameter int WIN_W = 12
) (
  input  logic [CFG_W-1:0] idx,
  input  logic [WIN_W-1:0] off,
  output logic             hit,
  output logic [CFG_W-1:0] addr
);
  logic             found;
  logic [DEV_W-1:0] slot;
  logic             unused_off;

  assign unused_off = ^off[WIN_W-1:3];

  // Scan from the top so the last match is the lowest set bit.
  always_comb begin
    found = 1'b0;
    slot  = '0;
    for (int b = CFG_W - 1; b >= SLOT_LO; b--) begin
      if (idx[b]) begin
        found = 1'b1;
        slot  = DEV_W'(b);
      end
    end
  end

  always_comb begin
    if (idx[CFG_W-1]) begin
      hit  = 1'b1;
      addr = idx | {{(CFG_W-2){1'b0}}, off[1:0]};
    end else if (idx[0]) begin
      hit  = 1'b1;
      addr = {idx[CFG_W-1:3], off[2:0]};
    end else if (found) begin
      hit  = 1'b1;
      addr = {1'b1, {(CFG_W-1-DEV_W-SLOT_LO){1'b0}}, slot, idx[10:8], idx[7:3], off[2:0]};
    end else begin
      hit  = 1'b0;
      addr = '0;
    end
  end
endmodule

// File: rtl/cfgb_irq_route.sv
module cfgb_irq_route
  import cfgb_pkg::*;
#(
  parameter int NDEV     = 4,
  parameter int DEV_BASE = 11
) (
  input  logic [4*NDEV-1:0]    dev_irq,
  output logic [IRQ_LINES-1:0] irq_line
);
  localparam int NPIN = 4 * NDEV;

  function automatic logic [NPIN-1:0] line_mask(input int line);
    logic [NPIN-1:0] m;
    m = '0;
    for (int k = 0; k < NDEV; k++) begin
      for (int p = 0; p < 4; p++) begin
        if (((p + DEV_BASE + k) % IRQ_LINES) == line) m[4*k+p] = 1'b1;
      end
    end
    return m;
  endfunction

  for (genvar n = 0; n < IRQ_LINES; n++) begin : g_line
    localparam logic [NPIN-1:0] MASK = line_mask(n);
    assign irq_line[n] = |(dev_irq & MASK);
  end
endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq
  import cfgb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_valid,
  output logic             host_ready,
  input  logic             host_write,
  input  logic             host_win,
  input  logic [CFG_W-1:0] host_wdata,
  input  logic             xl_hit,
  input  logic [CFG_W-1:0] xl_addr,
  output logic [CFG_W-1:0] idx_q,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [CFG_W-1:0] rsp_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic             dn_write,
  output logic [CFG_W-1:0] dn_addr,
  output logic [CFG_W-1:0] dn_wdata,
  input  logic             dn_rsp_valid,
  input  logic [CFG_W-1:0] dn_rsp_data
);
  cfgb_state_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx_q    <= '0;
      rsp_data <= '0;
      dn_addr  <= '0;
      dn_write <= 1'b0;
      dn_wdata <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (host_valid) begin
            if (!host_win) begin
              if (host_write) idx_q <= host_wdata;
              rsp_data <= host_write ? '0 : idx_q;
              st       <= ST_RESP;
            end else if (!xl_hit) begin
              rsp_data <= host_write ? '0 : CFG_NO_DEV;
              st       <= ST_RESP;
            end else begin
              dn_addr  <= xl_addr;
              dn_write <= host_write;
              dn_wdata <= host_wdata;
              st       <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (dn_ready) begin
            if (dn_write) begin
              rsp_data <= '0;
              st       <= ST_RESP;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (dn_rsp_valid) begin
            rsp_data <= dn_rsp_data;
            st       <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign host_ready = (st == ST_IDLE);
  assign dn_valid   = (st == ST_ISSUE);
  assign rsp_valid  = (st == ST_RESP);
endmodule

// File: rtl/cfg_xlate_bridge.sv
module cfg_xlate_bridge
  import cfgb_pkg::*;
#(
  parameter int WIN_W    = 12,
  parameter int NDEV     = 4,
  parameter int DEV_BASE = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_valid,
  output logic                 host_ready,
  input  logic                 host_write,
  input  logic [WIN_W:0]       host_addr,
  input  logic [CFG_W-1:0]     host_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [CFG_W-1:0]     rsp_data,
  output logic                 dn_valid,
  input  logic                 dn_ready,
  output logic                 dn_write,
  output logic [CFG_W-1:0]     dn_addr,
  output logic [CFG_W-1:0]     dn_wdata,
  input  logic                 dn_rsp_valid,
  input  logic [CFG_W-1:0]     dn_rsp_data,
  input  logic [4*NDEV-1:0]    dev_irq,
  output logic [IRQ_LINES-1:0] irq_line
);
  logic [CFG_W-1:0] idx_q;
  logic             xl_hit;
  logic [CFG_W-1:0] xl_addr;

  cfgb_xlate #(.WIN_W(WIN_W)) u_xlate (
    .idx  (idx_q),
    .off  (host_addr[WIN_W-1:0]),
    .hit  (xl_hit),
    .addr (xl_addr)
  );

  cfgb_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_valid   (host_valid),
    .host_ready   (host_ready),
    .host_write   (host_write),
    .host_win     (host_addr[WIN_W]),
    .host_wdata   (host_wdata),
    .xl_hit       (xl_hit),
    .xl_addr      (xl_addr),
    .idx_q        (idx_q),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_data     (rsp_data),
    .dn_valid     (dn_valid),
    .dn_ready     (dn_ready),
    .dn_write     (dn_write),
    .dn_addr      (dn_addr),
    .dn_wdata     (dn_wdata),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_data  (dn_rsp_data)
  );

  cfgb_irq_route #(.NDEV(NDEV), .DEV_BASE(DEV_BASE)) u_irq (
    .dev_irq  (dev_irq),
    .irq_line (irq_line)
  );
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker #(
  parameter int NDEV = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_data,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic              dn_write,
  input logic [31:0]       dn_addr,
  input logic [31:0]       dn_wdata,
  input logic [4*NDEV-1:0] dev_irq,
  input logic [3:0]        irq_line
);
  // R7: downstream request held stable under back-pressure
  p_dn_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_write) && $stable(dn_wdata));

  // R7: a downstream request and a host response never overlap
  p_one_side_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_valid && rsp_valid));

  // R8: host response held stable under back-pressure
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R8: no new request taken while a response is pending
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !host_ready);

  // R9: quiet pins give quiet lines
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq == '0) |-> (irq_line == 4'b0000));

  // R10: first cycle out of reset is idle
  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> host_ready && !dn_valid && !rsp_valid);
endmodule

bind cfg_xlate_bridge cfgb_checker #(.NDEV(NDEV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ready (host_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .dn_valid   (dn_valid),
  .dn_ready   (dn_ready),
  .dn_write   (dn_write),
  .dn_addr    (dn_addr),
  .dn_wdata   (dn_wdata),
  .dev_irq    (dev_irq),
  .irq_line   (irq_line)
);

// File: tb/cfg_xlate_bridge_test.sv
module cfg_xlate_bridge_test;
  localparam int NDEV = 2;
  localparam int DEV_BASE = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [12:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic rsp_ready = 1'b0, dn_ready = 1'b0, dn_rsp_valid = 1'b0;
  logic [31:0] dn_rsp_data = '0;
  logic [4*NDEV-1:0] dev_irq = '0;
  logic host_ready, rsp_valid, dn_valid, dn_write;
  logic [31:0] rsp_data, dn_addr, dn_wdata;
  logic [3:0] irq_line;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cfg_xlate_bridge #(.WIN_W(12), .NDEV(NDEV), .DEV_BASE(DEV_BASE)) uut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_addr(host_addr), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp_data(dn_rsp_data), .dev_irq(dev_irq), .irq_line(irq_line)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Arithmetic model: bit 32 = request goes downstream
  function automatic logic [32:0] model(input logic [31:0] idx, input logic [11:0] off);
    if (idx[31]) return {1'b1, idx | {30'd0, off[1:0]}};
    if (idx[0]) return {1'b1, (idx & ~32'd7) + {29'd0, off[2:0]}};
    for (int b = 11; b <= 30; b++) begin
      if (idx[b])
        return {1'b1, 32'h8000_0000 + (32'(b) << 11) + (32'(idx[10:8]) << 8)
                      + (32'(idx[7:3]) << 3) + 32'(off[2:0])};
    end
    return {1'b0, 32'hFFFF_FFFF};
  endfunction

  task automatic access(input logic wr, input logic win, input logic [11:0] off,
                        input logic [31:0] wd, input int stall, input logic [31:0] reply,
                        output logic saw_dn, output logic [31:0] got_addr,
                        output logic got_wr, output logic [31:0] got_wd,
                        output logic [31:0] got_data, output logic busy_err);
    int dn_wait, rs_wait;
    logic done;
    dn_wait = 0; rs_wait = 0; done = 1'b0;
    saw_dn = 1'b0; got_addr = '0; got_wr = 1'b0; got_wd = '0; got_data = '0; busy_err = 1'b0;
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_addr = {win, off}; host_wdata = wd;
    @(negedge clk);
    host_valid = 1'b0;
    for (int c = 0; c < 60 && !done; c++) begin
      if (rsp_ready) begin
        rsp_ready = 1'b0;
        done = 1'b1;
      end else begin
        if (host_ready) busy_err = 1'b1;
        if (dn_ready) begin
          dn_ready = 1'b0;
          if (!wr) begin dn_rsp_valid = 1'b1; dn_rsp_data = reply; end
        end else if (dn_rsp_valid) begin
          dn_rsp_valid = 1'b0;
        end else if (dn_valid) begin
          saw_dn = 1'b1; got_addr = dn_addr; got_wr = dn_write; got_wd = dn_wdata;
          if (dn_wait < stall) dn_wait++; else dn_ready = 1'b1;
        end
        if (rsp_valid) begin
          got_data = rsp_data;
          if (rs_wait < stall) rs_wait++; else rsp_ready = 1'b1;
        end
      end
      if (!done) @(negedge clk);
    end
  endtask

  task automatic set_index(input logic [31:0] v);
    logic s, w, b; logic [31:0] a, d, r;
    access(1'b1, 1'b0, 12'h000, v, 0, 32'd0, s, a, w, d, r, b);
  endtask

  // Data-window access compared against the model
  task automatic data_check(input logic [31:0] idx, input logic [11:0] off, input logic wr,
                            input int stall, input string req);
    logic s, w, b; logic [31:0] a, d, r, reply, wd;
    logic [32:0] m;
    m = model(idx, off);
    reply = idx ^ 32'h5A5A_0F0F ^ {20'd0, off};
    wd = ~idx + 32'(off);
    access(wr, 1'b1, off, wd, stall, reply, s, a, w, d, r, b);
    if (m[32]) begin
      chk(s && a == m[31:0], req, a, m[31:0]);
      if (wr) chk(s && w && d == wd && r == 32'd0, "R7 write data", d, wd);
      else    chk(s && !w && r == reply, "R7 read data", r, reply);
    end else begin
      chk(!s, "R6 no downstream request", {31'd0, s}, 32'd0);
      chk(r == (wr ? 32'd0 : 32'hFFFF_FFFF), "R6 local reply", r, wr ? 32'd0 : 32'hFFFF_FFFF);
    end
    if (stall > 0) chk(!b, "R8 host_ready low while busy", {31'd0, b}, 32'd0);
  endtask

  initial begin
    logic s, w, b; logic [31:0] a, d, r;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(host_ready && !dn_valid && !rsp_valid, "R10 outputs in reset",
        {29'd0, host_ready, dn_valid, rsp_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b0, 1'b0, 12'h000, 32'd0, 0, 32'd0, s, a, w, d, r, b);
    chk(r == 32'd0, "R10 index after reset", r, 32'd0);

    // R1: index write and readback at assorted offsets
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = 32'h1357_9BDF * 32'(i + 1) ^ 32'(i << 28);
      access(1'b1, 1'b0, 12'(i * 12'h1F3), v, i % 3, 32'd0, s, a, w, d, r, b);
      chk(!s && r == 32'd0, "R1 index write", r, 32'd0);
      access(1'b0, 1'b0, 12'(12'hFFF - 12'(i)), 32'd0, i % 2, 32'd0, s, a, w, d, r, b);
      chk(r == v, "R1 index readback", r, v);
    end

    // R4/R5: every slot bit, every function, every low offset
    for (int bit_pos = 11; bit_pos <= 30; bit_pos++) begin
      for (int f = 0; f < 8; f++) begin
        for (int o = 0; o < 8; o++) begin
          logic [31:0] idx;
          idx = (32'd1 << bit_pos) | ((bit_pos < 29) ? (32'd1 << 29) : 32'd0)
              | (32'(f) << 8) | (32'((bit_pos * 7 + f * 3 + o) & 31) << 3)
              | (32'(o & 1) << 1) | (32'(o & 2) << 1);
          set_index(idx);
          data_check(idx, 12'(o + o * 12'h140), ((o + f) % 2) == 1, (f + o) % 4, "R4 R5 slot-select address");
        end
      end
    end

    // R2: pass-through form
    for (int i = 0; i < 16; i++) begin
      logic [31:0] idx;
      idx = 32'h8000_0000 | (32'h00AB_CDE0 ^ 32'(i << 12)) | 32'(i & 3);
      set_index(idx);
      data_check(idx, 12'(i * 12'h0F1 + 3 - i), i[0], i % 3, "R2 pass-through address");
    end

    // R3: other-bus form
    for (int i = 0; i < 16; i++) begin
      logic [31:0] idx;
      idx = (32'(i) << 16) | (32'(i * 5) << 11) | 32'h0000_00F5 | 32'(i & 6);
      set_index(idx);
      data_check(idx, 12'(i * 12'h0A7), i[1], i % 4, "R3 other-bus address");
    end

    // R6: no slot selected
    for (int i = 0; i < 8; i++) begin
      logic [31:0] idx;
      idx = (32'(i) << 8) | (32'(i * 9) << 3) & 32'h0000_07FE;
      set_index(idx);
      data_check(idx, 12'(i), i[0], i % 2, "R6 empty slot");
    end

    // R9: exhaustive interrupt patterns
    for (int v = 0; v < (1 << (4 * NDEV)); v++) begin
      logic [3:0] exp;
      @(negedge clk);
      dev_irq = (4 * NDEV)'(v);
      #1;
      exp = '0;
      for (int k = 0; k < NDEV; k++)
        for (int p = 0; p < 4; p++)
          if (((v >> (4 * k + p)) & 1) == 1) exp[(p + DEV_BASE + k) % 4] = 1'b1;
      chk(irq_line == exp, "R9 interrupt rotation", {28'd0, irq_line}, {28'd0, exp});
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R7 watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule